// File: doc/BRIEF.md
# Selectable Comma Character Framer

The framer receives a recovered bit stream as 10-bit words that are not yet aligned, one word per character clock. It looks for a framing character at every one of the ten possible bit offsets. When it finds one, it fixes that offset as the character boundary. From then on it cuts every later 10-bit character out of the stream at that boundary. It presents each aligned character with a valid strobe. A one-cycle pulse marks each cycle in which a new alignment is adopted.

A select input chooses how strict the match is. In the looser mode only the leading eight bits of the comma are compared. In the stricter mode both full 10-bit disparity forms of the K28.5 character are compared. An enable input freezes the current alignment so that no bit sequence in the stream can move it. A downstream 8B/10B decoder consumes the aligned characters. Link logic that must know when the boundary moved watches the framing-event pulse.

Top module: `comma_framer`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `out_valid`, `frame_event`, `locked` and `out_offset` become 0 after that edge.
- R2: Bit `in_char[9]` is the earliest received bit of a word. An offset k (0 to 9) means a character starts k bits after the first bit of the previous accepted word. A framing character that starts at any stream bit position p is adopted with `out_offset` = p mod 10.
- R3: With `char_sel` = 0, a candidate matches when its first eight bits are 00111110 or 11000001. Its last two bits are ignored, so 0011111001 also matches.
- R4: With `char_sel` = 1, a candidate matches only when it is exactly 0011111010 or 1100000101. A candidate that agrees in its first eight bits but differs in its last two is not adopted: `out_offset` stays the same and no `frame_event` occurs.
- R5: Once locked, each accepted word produces `out_char`, the ten stream bits that start at the current offset within the 19-bit window. The window is the previous word followed by bits 9 to 1 of the current word. The first stream bit is placed in `out_char[9]`.
- R6: When a new alignment is accepted, `frame_event` is high for exactly one cycle, one cycle after the word that completed the match. In that same cycle `out_valid` is 1, `locked` is 1 and `out_char` holds the framing character. `locked` never returns to 0 except through reset.
- R7: A framing character found again at the current offset produces no `frame_event`.
- R8: While `frame_en` = 0, no stream content changes `out_offset`, and no `frame_event` occurs. Aligned characters are still produced at the held offset. Once `frame_en` returns to 1, the next framing character at a different offset is adopted.
- R9: `out_valid` is 1 in the cycle after each word accepted with `in_valid` = 1, but only once `locked` is 1. It is 0 after a cycle with `in_valid` = 0, and it is 0 before the first alignment.
- R10: When framing characters match at more than one offset in the same window, the lowest offset is adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_char` carries a new 10-bit word this cycle |
| in_char | input | 10 | Unaligned stream word; bit 9 received first |
| frame_en | input | 1 | 1 = alignment may change, 0 = alignment frozen |
| char_sel | input | 1 | 0 = 8-bit comma compare, 1 = full 10-bit K28.5 compare |
| out_char | output | 10 | Aligned character; bit 9 is the first bit in the stream |
| out_valid | output | 1 | `out_char` holds a new aligned character |
| frame_event | output | 1 | One-cycle pulse when a new alignment is adopted |
| out_offset | output | 4 | Current boundary offset, 0 to 9 |
| locked | output | 1 | At least one alignment has been adopted since reset |

## Verification
Every result is registered once. The aligned character, the valid strobe, the framing-event pulse and the new offset all appear one cycle after the word that completes the match. A comma that straddles two words is therefore reported one cycle after its second word.

The driver applies one word, or one idle cycle, per falling edge. For each one it pushes the predicted outputs into a queue. The monitor pops one entry per rising edge and compares the outputs one time unit after that edge, so each prediction is matched with exactly the edge that consumed its word. Directed checks run in the idle cycle after each scenario. They read the held offset and the running count of framing events, and they compare these with the stream position at which each comma was inserted.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int unsigned SYM_W  = 10;
  localparam int unsigned HEAD_W = 8;
  localparam int unsigned NOFF   = SYM_W;
  localparam int unsigned WIN_W  = SYM_W + NOFF - 1;
  localparam int unsigned OFF_W  = $clog2(NOFF);

  localparam logic [SYM_W-1:0] K_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] K_POS = 10'b1100000101;

  typedef enum logic {
    MATCH_HEAD = 1'b0,
    MATCH_FULL = 1'b1
  } match_mode_e;
endpackage

// File: rtl/cfr_pattern_match.sv
module cfr_pattern_match
  import cfr_pkg::*;
(
  input  logic [SYM_W-1:0] cand,
  input  match_mode_e      mode,
  output logic             hit
);
  logic head_hit;
  logic full_hit;

  always_comb begin
    head_hit = (cand[SYM_W-1 -: HEAD_W] == K_NEG[SYM_W-1 -: HEAD_W]) ||
               (cand[SYM_W-1 -: HEAD_W] == K_POS[SYM_W-1 -: HEAD_W]);
    full_hit = (cand == K_NEG) || (cand == K_POS);
    hit      = (mode == MATCH_FULL) ? full_hit : head_hit;
  end
endmodule

// File: rtl/cfr_offset_scan.sv
module cfr_offset_scan
  import cfr_pkg::*;
(
  input  logic [WIN_W-1:0] window,
  input  match_mode_e      mode,
  output logic             hit_any,
  output logic [OFF_W-1:0] hit_off
);
  logic [NOFF-1:0] hit_vec;

  for (genvar k = 0; k < NOFF; k++) begin : g_off
    cfr_pattern_match u_match (
      .cand (window[WIN_W-1-k -: SYM_W]),
      .mode (mode),
      .hit  (hit_vec[k])
    );
  end

  // lowest offset wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit_any = 1'b0;
    hit_off = '0;
    for (int k = NOFF - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        hit_any = 1'b1;
        hit_off = OFF_W'(k);
      end
    end
  end
endmodule

// File: rtl/cfr_align_ctrl.sv
module cfr_align_ctrl
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             frame_en,
  input  logic             hit_any,
  input  logic [OFF_W-1:0] hit_off,
  output logic [OFF_W-1:0] off_d,
  output logic             locked_d,
  output logic             event_d,
  output logic [OFF_W-1:0] off_q,
  output logic             locked_q
);
  always_comb begin
    event_d  = step && frame_en && hit_any && (!locked_q || (hit_off != off_q));
    off_d    = event_d ? hit_off : off_q;
    locked_d = locked_q || event_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      off_q    <= off_d;
      locked_q <= locked_d;
    end
  end

  // R8: a disabled framer keeps its boundary
  a_r8_frozen_offset: assert property (@(posedge clk) disable iff (rst)
    !frame_en |=> $stable(off_q));

  // R6: lock is sticky until reset
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_char,
  input  logic             frame_en,
  input  logic             char_sel,
  output logic [SYM_W-1:0] out_char,
  output logic             out_valid,
  output logic             frame_event,
  output logic [OFF_W-1:0] out_offset,
  output logic             locked
);
  logic [SYM_W-1:0] prev_q;
  logic [WIN_W-1:0] window;
  logic             hit_any;
  logic [OFF_W-1:0] hit_off;
  logic [OFF_W-1:0] off_d;
  logic             locked_d;
  logic             event_d;
  logic [OFF_W-1:0] shamt;
  logic [WIN_W-1:0] shifted;
  logic [SYM_W-1:0] aligned;
  match_mode_e      mode;

  assign window = {prev_q, in_char[SYM_W-1:SYM_W-NOFF+1]};
  assign mode   = char_sel ? MATCH_FULL : MATCH_HEAD;

  cfr_offset_scan u_scan (
    .window  (window),
    .mode    (mode),
    .hit_any (hit_any),
    .hit_off (hit_off)
  );

  cfr_align_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .step     (in_valid),
    .frame_en (frame_en),
    .hit_any  (hit_any),
    .hit_off  (hit_off),
    .off_d    (off_d),
    .locked_d (locked_d),
    .event_d  (event_d),
    .off_q    (out_offset),
    .locked_q (locked)
  );

  // offset k selects window bits [WIN_W-1-k : WIN_W-SYM_W-k]
  always_comb begin
    shamt   = OFF_W'(NOFF - 1) - off_d;
    shifted = window >> shamt;
    aligned = shifted[SYM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= '0;
      out_char    <= '0;
      out_valid   <= 1'b0;
      frame_event <= 1'b0;
    end else begin
      out_valid   <= in_valid && locked_d;
      frame_event <= event_d;
      if (in_valid) begin
        prev_q   <= in_char;
        out_char <= aligned;
      end
    end
  end

  // R6: every framing event comes with a valid character
  a_r6_event_with_valid: assert property (@(posedge clk) disable iff (rst)
    frame_event |-> out_valid);

  // R9: no valid character before the first alignment
  a_r9_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> locked);

  // R2: the reported boundary only moves together with a framing event
  a_r2_offset_moves_on_event: assert property (@(posedge clk) disable iff (rst)
    (out_offset != $past(out_offset)) |-> frame_event);
endmodule

// File: tb/comma_framer_tb.sv
module comma_framer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [9:0] in_char = '0;
  logic       frame_en = 1'b1;
  logic       char_sel = 1'b1;
  logic [9:0] out_char;
  logic       out_valid;
  logic       frame_event;
  logic [3:0] out_offset;
  logic       locked;

  always #2 clk = ~clk;

  comma_framer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .frame_en(frame_en), .char_sel(char_sel), .out_char(out_char),
    .out_valid(out_valid), .frame_event(frame_event),
    .out_offset(out_offset), .locked(locked)
  );

  typedef struct {
    bit       v;
    bit       ev;
    bit       lk;
    bit [3:0] off;
    bit [9:0] ch;
  } exp_t;

  exp_t sbq[$];
  bit   bq[$];
  int   checks = 0;
  int   errors = 0;
  int   ev_seen = 0;
  int   v_seen = 0;
  int   nbits = 0;
  bit   lastbit = 1'b0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  bit [9:0] m_prev = '0;
  int       m_off = 0;
  bit       m_lk = 1'b0;

  localparam bit [9:0] KN  = 10'b0011111010;
  localparam bit [9:0] KP  = 10'b1100000101;
  localparam bit [9:0] BAD = 10'b0011111001;
  localparam bit [9:0] D0  = 10'b0110011010;
  localparam bit [9:0] D1  = 10'b1001100101;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pat_hit(bit [9:0] c, bit s);
    if (s) return (c == KN) || (c == KP);
    return (c[9:2] == 8'b00111110) || (c[9:2] == 8'b11000001);
  endfunction

  task automatic drive_chunk(bit [9:0] c);
    bit [19:0] w;
    int        found;
    exp_t      e;
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    w = {m_prev, c};
    found = -1;
    for (int k = 0; k < 10; k++)
      if (found < 0 && pat_hit(w[19-k -: 10], char_sel)) found = k;
    e.ev = frame_en && (found >= 0) && (!m_lk || found != m_off);
    if (e.ev) begin
      m_off = found;
      m_lk  = 1'b1;
    end
    e.v   = m_lk;
    e.lk  = m_lk;
    e.off = 4'(m_off);
    e.ch  = w[19-m_off -: 10];
    m_prev = c;
    sbq.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    in_char  = '0;
    e.v = 1'b0; e.ev = 1'b0; e.lk = m_lk; e.off = 4'(m_off); e.ch = '0;
    sbq.push_back(e);
  endtask

  task automatic push_bit(bit b);
    bq.push_back(b);
    lastbit = b;
    nbits++;
  endtask

  task automatic push_alt(int n);
    for (int i = 0; i < n; i++) push_bit(~lastbit);
  endtask

  task automatic push_char(bit [9:0] c);
    for (int i = 9; i >= 0; i--) push_bit(c[i]);
  endtask

  task automatic flush(bit gap);
    bit [9:0] c;
    while (bq.size() >= 10) begin
      for (int i = 9; i >= 0; i--) c[i] = bq.pop_front();
      drive_chunk(c);
      if (gap) idle();
    end
  endtask

  // monitor: one expected entry per rising edge
  initial begin
    exp_t e;
    wait (mon_on);
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk("R9 out_valid", int'(out_valid), int'(e.v));
        chk("R6 frame_event", int'(frame_event), int'(e.ev));
        chk("R6 locked", int'(locked), int'(e.lk));
        chk("R2 out_offset", int'(out_offset), int'(e.off));
        if (e.v) chk("R5 out_char", int'(out_char), int'(e.ch));
        if (frame_event) ev_seen++;
        if (out_valid) v_seen++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    int e0;
    int v0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 frame_event", int'(frame_event), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 out_offset", int'(out_offset), 0);
    mon_on = 1'b1;

    // S1: full compare, comma at phase 3
    frame_en = 1'b1; char_sel = 1'b1;
    push_alt(23); flush(0); idle();
    chk("R9 no valid before lock", int'(out_valid), 0);
    chk("R9 unlocked", int'(locked), 0);
    e0 = ev_seen;
    p = nbits; push_char(KN);
    push_char(D0); push_char(D1); push_char(D0);
    flush(0); idle();
    chk("R2 adopted offset", int'(out_offset), p % 10);
    chk("R6 one event", ev_seen - e0, 1);

    // S2: comma again at the same offset
    e0 = ev_seen;
    push_char(KP); push_char(D1); push_char(D0); push_char(KN);
    flush(0); idle();
    chk("R7 no event on same offset", ev_seen - e0, 0);
    chk("R7 offset kept", int'(out_offset), p % 10);

    // S3: phase shift, other disparity
    push_alt(5);
    e0 = ev_seen;
    p = nbits; push_char(KP); push_char(D0);
    flush(0); idle();
    chk("R2 new offset", int'(out_offset), p % 10);
    chk("R6 event on realign", ev_seen - e0, 1);

    // S4: 8-bit-only comma under full compare
    push_alt(2);
    e0 = ev_seen;
    push_char(BAD); push_char(D1); push_char(D0);
    flush(0); idle();
    chk("R4 offset unchanged", int'(out_offset), 8);
    chk("R4 no event", ev_seen - e0, 0);

    // S5: same character under 8-bit compare
    char_sel = 1'b0;
    push_alt(3);
    e0 = ev_seen;
    p = nbits; push_char(BAD); push_char(D1); push_char(D0);
    flush(0); idle();
    chk("R3 head match adopted", int'(out_offset), p % 10);
    chk("R3 event", ev_seen - e0, 1);

    // S6: framer disabled
    frame_en = 1'b0;
    push_alt(4);
    e0 = ev_seen; v0 = v_seen;
    p = nbits; push_char(KN); push_char(D0); push_char(D1);
    flush(0); idle();
    chk("R8 offset frozen", int'(out_offset), 3);
    chk("R8 no event", ev_seen - e0, 0);
    chk("R8 chars still valid", int'(v_seen > v0), 1);
    frame_en = 1'b1;
    e0 = ev_seen;
    p = nbits; push_char(KN); push_char(D0); push_char(D1);
    flush(0); idle();
    chk("R8 re-enabled adopts", int'(out_offset), p % 10);
    chk("R8 re-enabled event", ev_seen - e0, 1);

    // S7: two heads in one window at offsets p and p+5
    push_alt(5);
    e0 = ev_seen;
    p = nbits;
    for (int i = 12; i >= 0; i--) push_bit(13'b1100000111110 >> i);
    push_alt(20);
    flush(0); idle();
    chk("R10 lowest offset", int'(out_offset), p % 10);
    chk("R10 event", ev_seen - e0, 1);

    // S8: gapped words after lock
    v0 = v_seen;
    push_char(D0); push_char(D1); push_char(D0); push_char(D1);
    flush(1); idle();
    chk("R9 valid per word", v_seen - v0, 4);

    repeat (4) idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule